// File: doc/BRIEF.md
# 6502 Operand Address Generator

This unit resolves the effective address of one 6502-style operand. A sequencer pulses `start` with an addressing-mode code, the program counter that points at the first operand byte, the two index registers and, for branches, whether the branch condition holds. The unit then fetches the operand bytes and any pointer bytes through a single-port synchronous byte memory. When it has finished, it returns the effective address, the program counter advanced past the operand, and the timing penalty the access costs.

Zero-page arithmetic wraps inside page zero. Indexing that moves the address into another 256-byte page costs one extra cycle. Relative branches get their target and their full cycle count. Instruction decode, the ALU and the final data access are left to the surrounding core.

Top module: `opaddr_gen`

## Requirements
- R1: After reset, `done` and `mem_rd` are 0 and `ea`, `pc_out`, `extra_cyc` and `br_cyc` are 0.
- R2: The mode codes are 0 zero page, 1 zero page+X and 2 zero page+Y. For these, `ea` = {8'h00, (op + idx) mod 256}, where op is the byte at `pc_in` and idx is 0, X or Y. `pc_out` = `pc_in`+1.
- R3: The mode codes are 3 absolute, 4 absolute+X and 5 absolute+Y. The base is {byte at `pc_in`+1, byte at `pc_in`}, taken low byte first. `ea` = base + idx, wrapping at 16 bits, and `pc_out` = `pc_in`+2.
- R4: `extra_cyc` is 1 for modes 4, 5 and 7 when `ea[15:8]` differs from the high byte of the unindexed base. Otherwise it is 0 for every mode other than 9.
- R5: For mode 6 (indexed indirect), p = (op + X) mod 256. `ea` = {byte at (p+1) mod 256, byte at p} and `pc_out` = `pc_in`+1.
- R6: For mode 7 (indirect indexed), the pointer is {byte at (op+1) mod 256, byte at op}. `ea` = pointer + Y and `pc_out` = `pc_in`+1.
- R7: For mode 8 (indirect jump), the pointer P is the two bytes at `pc_in` and `pc_in`+1, low byte first. `ea` = {byte at P+1, byte at P}, where P+1 is a full 16-bit increment. `pc_out` = `pc_in`+2.
- R8: For mode 9 (relative), `ea` = `pc_in`+1 plus the sign-extended offset byte. `pc_out` = `ea` when `br_take` is 1 and `pc_in`+1 when it is 0.
- R9: For mode 9, `br_cyc` is 2 when the branch is not taken, 3 when it is taken within the page of `pc_in`+1, and 4 when it is taken into another page. `extra_cyc` is 1 only in the last case. `br_cyc` is 0 for every other mode.
- R10: Codes 10 to 15 perform no memory read and return `ea` = 0, `pc_out` = `pc_in`, and zero penalties.
- R11: Each read takes two cycles. `done` is high for exactly one cycle, 2n+1 clock edges after the edge that samples `start`. n is 1 for modes 0, 1, 2 and 9, 2 for modes 3 to 5, 3 for modes 6 and 7, 4 for mode 8, and 0 for other codes.
- R12: Inputs are captured at `start`. Changes to the inputs, and further `start` pulses while an operation is in progress, alter neither the result nor the number of `done` pulses.
- R13: `mem_rdata` is taken one cycle after `mem_rd` is high. `mem_rd` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an address computation |
| mode | input | 4 | Addressing-mode code |
| pc_in | input | AW | Address of the first operand byte |
| x_in | input | 8 | X index |
| y_in | input | 8 | Y index |
| br_take | input | 1 | Branch condition holds (mode 9) |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | AW | Memory read address |
| mem_rdata | input | 8 | Read data, valid one cycle after the strobe |
| done | output | 1 | One-cycle result-valid pulse |
| ea | output | AW | Effective address or branch target |
| pc_out | output | AW | Program counter after the operand |
| extra_cyc | output | 2 | Page-crossing penalty cycles |
| br_cyc | output | 3 | Total branch cycles (mode 9) |

## Verification
A wrong read counter or a corrupted latched mode changes the distance from `start` to `done`, and that shows on the very first operation affected. A bad pointer-address step, such as a missing zero-page wrap, reads the wrong byte and corrupts `ea` in the same `done` cycle. Because the memory contents are a scrambled function of the address, such an error almost never matches by chance. Page-crossing and branch cycle errors appear only when a crossing actually happens, so the sweep spreads its bases and indexes until crossings occur in both directions.

// File: rtl/opaddr_gen.sv
module opaddr_gen #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    mode,
  input  logic [AW-1:0] pc_in,
  input  logic [7:0]    x_in,
  input  logic [7:0]    y_in,
  input  logic          br_take,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_rdata,
  output logic          done,
  output logic [AW-1:0] ea,
  output logic [AW-1:0] pc_out,
  output logic [1:0]    extra_cyc,
  output logic [2:0]    br_cyc
);
  localparam int HW = AW - 8;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_CALC} st_t;

  st_t           st;
  logic [3:0]    md;
  logic [AW-1:0] pc_r;
  logic [7:0]    xr, yr;
  logic          tk;
  logic [1:0]    k;
  logic [7:0]    b0, b1, b2, b3;
  logic          busy;

  function automatic logic [2:0] nreads(input logic [3:0] m);
    case (m)
      4'd0, 4'd1, 4'd2, 4'd9: nreads = 3'd1;
      4'd3, 4'd4, 4'd5:       nreads = 3'd2;
      4'd6, 4'd7:             nreads = 3'd3;
      4'd8:                   nreads = 3'd4;
      default:                nreads = 3'd0;
    endcase
  endfunction

  function automatic logic [AW-1:0] zx(input logic [7:0] v);
    zx = {{HW{1'b0}}, v};
  endfunction

  assign busy = (st != S_IDLE);

  logic [7:0] zp_ix;
  assign zp_ix = b0 + xr;

  logic [AW-1:0] ra;
  logic          op_fetch;
  always_comb begin
    ra = pc_r;
    op_fetch = 1'b0;
    case (k)
      2'd0: begin ra = pc_r; op_fetch = 1'b1; end
      2'd1: begin
        case (md)
          4'd6:    ra = zx(zp_ix);
          4'd7:    ra = zx(b0);
          default: begin ra = pc_r; op_fetch = 1'b1; end
        endcase
      end
      2'd2: begin
        case (md)
          4'd6:    ra = zx(zp_ix + 8'd1);
          4'd7:    ra = zx(b0 + 8'd1);
          default: ra = {b1, b0};
        endcase
      end
      default: ra = {b1, b0} + 1'b1;
    endcase
  end

  assign mem_rd   = (st == S_ISSUE);
  assign mem_addr = ra;

  logic [AW-1:0] abs_base, ind_base, e_c, npc_c, tgt;
  logic          cross_c;
  logic [1:0]    ex_c;
  logic [2:0]    bc_c;
  assign abs_base = {b1, b0};
  assign ind_base = {b2, b1};
  assign tgt      = pc_r + {{HW{b0[7]}}, b0};

  always_comb begin
    e_c = '0;
    npc_c = pc_r;
    cross_c = 1'b0;
    ex_c = 2'd0;
    bc_c = 3'd0;
    case (md)
      4'd0: e_c = zx(b0);
      4'd1: e_c = zx(b0 + xr);
      4'd2: e_c = zx(b0 + yr);
      4'd3: e_c = abs_base;
      4'd4: begin
        e_c = abs_base + zx(xr);
        cross_c = e_c[AW-1:8] != abs_base[AW-1:8];
      end
      4'd5: begin
        e_c = abs_base + zx(yr);
        cross_c = e_c[AW-1:8] != abs_base[AW-1:8];
      end
      4'd6: e_c = ind_base;
      4'd7: begin
        e_c = ind_base + zx(yr);
        cross_c = e_c[AW-1:8] != ind_base[AW-1:8];
      end
      4'd8: e_c = {b3, b2};
      4'd9: begin
        e_c = tgt;
        if (tk) begin
          npc_c = tgt;
          cross_c = tgt[AW-1:8] != pc_r[AW-1:8];
          bc_c = cross_c ? 3'd4 : 3'd3;
        end else begin
          bc_c = 3'd2;
        end
      end
      default: e_c = '0;
    endcase
    ex_c = {1'b0, cross_c};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      md <= '0;
      pc_r <= '0;
      xr <= '0;
      yr <= '0;
      tk <= 1'b0;
      k <= '0;
      b0 <= '0;
      b1 <= '0;
      b2 <= '0;
      b3 <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          md <= mode;
          pc_r <= pc_in;
          xr <= x_in;
          yr <= y_in;
          tk <= br_take;
          k <= '0;
          st <= (nreads(mode) == 3'd0) ? S_CALC : S_ISSUE;
        end
        S_ISSUE: st <= S_WAIT;
        S_WAIT: begin
          case (k)
            2'd0: b0 <= mem_rdata;
            2'd1: b1 <= mem_rdata;
            2'd2: b2 <= mem_rdata;
            default: b3 <= mem_rdata;
          endcase
          if (op_fetch) pc_r <= pc_r + 1'b1;
          if ({1'b0, k} == nreads(md) - 3'd1) st <= S_CALC;
          else begin
            k <= k + 2'd1;
            st <= S_ISSUE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
      ea <= '0;
      pc_out <= '0;
      extra_cyc <= '0;
      br_cyc <= '0;
    end else begin
      done <= (st == S_CALC);
      if (st == S_CALC) begin
        ea <= e_c;
        pc_out <= npc_c;
        extra_cyc <= ex_c;
        br_cyc <= bc_c;
      end
    end
  end
endmodule

// File: rtl/opaddr_gen_chk.sv
module opaddr_gen_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_rd,
  input logic          done,
  input logic [AW-1:0] ea,
  input logic [1:0]    extra_cyc,
  input logic [2:0]    br_cyc,
  input logic [3:0]    md,
  input logic          busy
);
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !done && !mem_rd);

  p_zp_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done && md <= 4'd2 |-> ea[AW-1:8] == '0);

  p_no_penalty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done && (md <= 4'd3 || md == 4'd6 || md == 4'd8 || md >= 4'd10) |-> extra_cyc == 2'd0);

  p_br_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done && md == 4'd9 |-> br_cyc >= 3'd2 && br_cyc <= 3'd4);

  p_br_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done && md != 4'd9 |-> br_cyc == 3'd0);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_rd_spaced_r13: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);

  p_rd_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> busy);
endmodule

bind opaddr_gen opaddr_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .done(done), .ea(ea),
  .extra_cyc(extra_cyc), .br_cyc(br_cyc), .md(md), .busy(busy)
);

// File: tb/test_opaddr_gen.sv
`timescale 1ns/1ps
module test_opaddr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [15:0] pc_in = '0;
  logic [7:0]  x_in = '0, y_in = '0;
  logic        br_take = 1'b0;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata = '0;
  logic        done;
  logic [15:0] ea, pc_out;
  logic [1:0]  extra_cyc;
  logic [2:0]  br_cyc;

  int vecs = 0;
  int bad = 0;
  bit finished = 0;
  bit prev_rd = 0;

  always #4 clk = ~clk;

  opaddr_gen #(.AW(16)) i_opaddr_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .pc_in(pc_in),
    .x_in(x_in), .y_in(y_in), .br_take(br_take), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .done(done), .ea(ea),
    .pc_out(pc_out), .extra_cyc(extra_cyc), .br_cyc(br_cyc)
  );

  function automatic logic [7:0] fb(input logic [15:0] a);
    logic [7:0] m;
    m = a[7:0] * 8'd13;
    return m ^ a[15:8] ^ 8'h3C;
  endfunction

  always_ff @(posedge clk) if (mem_rd) mem_rdata <= fb(mem_addr);

  always @(negedge clk) begin
    if (rst_n && prev_rd && mem_rd) begin
      bad++;
      $display("FAIL R13 back-to-back reads act=1 exp=0");
    end
    prev_rd = mem_rd;
  end

  function automatic string rtag(input int m);
    if (m <= 2) return "R2";
    if (m <= 5) return "R3";
    if (m == 6) return "R5";
    if (m == 7) return "R6";
    if (m == 8) return "R7";
    if (m == 9) return "R8";
    return "R10";
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic run(input int m, input logic [15:0] pc, input logic [7:0] x,
                     input logic [7:0] y, input bit tk, input bit poke);
    logic [7:0]  o, p, lo, hi;
    logic [15:0] base, e, npc, nx, ptr;
    int n, ex, bc, lat, extra_done;
    o = fb(pc); ex = 0; bc = 0; e = 0; npc = pc; n = 0;
    case (m)
      0, 1, 2: begin
        p = o + ((m == 1) ? x : (m == 2) ? y : 8'd0);
        e = {8'h00, p}; npc = pc + 16'd1; n = 1;
      end
      3, 4, 5: begin
        base = {fb(pc + 16'd1), o};
        e = base + {8'h00, (m == 4) ? x : (m == 5) ? y : 8'd0};
        if (m != 3 && e[15:8] != base[15:8]) ex = 1;
        npc = pc + 16'd2; n = 2;
      end
      6: begin
        p = o + x; lo = fb({8'h00, p}); p = p + 8'd1; hi = fb({8'h00, p});
        e = {hi, lo}; npc = pc + 16'd1; n = 3;
      end
      7: begin
        lo = fb({8'h00, o}); p = o + 8'd1; hi = fb({8'h00, p});
        base = {hi, lo}; e = base + {8'h00, y};
        if (e[15:8] != base[15:8]) ex = 1;
        npc = pc + 16'd1; n = 3;
      end
      8: begin
        ptr = {fb(pc + 16'd1), o};
        e = {fb(ptr + 16'd1), fb(ptr)}; npc = pc + 16'd2; n = 4;
      end
      9: begin
        nx = pc + 16'd1; e = nx + {{8{o[7]}}, o}; n = 1;
        if (tk) begin
          npc = e;
          if (e[15:8] != nx[15:8]) begin ex = 1; bc = 4; end else bc = 3;
        end else begin
          npc = nx; bc = 2;
        end
      end
      default: ;
    endcase
    @(negedge clk);
    mode = 4'(m); pc_in = pc; x_in = x; y_in = y; br_take = tk; start = 1'b1;
    @(negedge clk);
    start = 1'b0; mode = ~mode; pc_in = ~pc; x_in = ~x; y_in = y + 8'd77; br_take = ~tk;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      start = (poke && lat == 2);
      if (poke && lat == 2) mode = 4'd3;
    end while (!done && lat < 40);
    start = 1'b0;
    vecs++;
    chk(lat == 2*n + 1, "R11", "latency", lat, 2*n + 1);
    chk(ea == e, rtag(m), "ea", ea, e);
    chk(pc_out == npc, rtag(m), "pc_out", pc_out, npc);
    chk(extra_cyc == 2'(ex), (m == 9) ? "R9" : "R4", "extra_cyc", extra_cyc, ex);
    chk(br_cyc == 3'(bc), "R9", "br_cyc", br_cyc, bc);
    if (poke) begin
      extra_done = 0;
      repeat (12) begin
        @(negedge clk);
        if (done) extra_done++;
      end
      chk(extra_done == 0, "R12", "spurious done", extra_done, 0);
    end
  endtask

  initial begin
    #1_520_000;
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    end
    $finish;
  end

  initial begin
    logic [15:0] wpc;
    repeat (3) @(negedge clk);
    vecs++;
    chk(done == 0 && mem_rd == 0, "R1", "done/mem_rd", {done, mem_rd}, 0);
    chk(ea == 0 && pc_out == 0 && extra_cyc == 0 && br_cyc == 0, "R1", "outputs",
        ea, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 0 && mem_rd == 0, "R1", "idle after release", {done, mem_rd}, 0);

    for (int m = 0; m <= 10; m++)
      for (int i = 0; i < 550; i++)
        run(m, 16'(i*331 + m*4099), 8'(i*7 + m), 8'(i*29 + 3), i[0], (i % 50) == 7);

    for (int m = 11; m <= 15; m++) run(m, 16'h1234, 8'h10, 8'h20, 1'b1, 1'b0);

    wpc = 16'h1200;
    for (int a = 0; a < 256; a++) if (fb({8'h12, 8'(a)}) == 8'hFF) wpc = {8'h12, 8'(a)};
    run(7, wpc, 8'h00, 8'hC0, 1'b0, 1'b1);
    run(6, wpc, 8'h00, 8'h00, 1'b0, 1'b0);
    run(6, 16'h0400, 8'hFF - fb(16'h0400), 8'h00, 1'b0, 1'b0);
    run(8, wpc, 8'h00, 8'h00, 1'b0, 1'b1);
    run(3, 16'hFFFF, 8'h00, 8'h00, 1'b0, 1'b0);
    run(4, 16'hFFFF, 8'hFF, 8'h00, 1'b0, 1'b0);
    run(9, 16'h00FE, 8'h00, 8'h00, 1'b1, 1'b0);
    run(9, 16'hFFFE, 8'h00, 8'h00, 1'b1, 1'b0);
    run(9, 16'h80FF, 8'h00, 8'h00, 1'b0, 1'b0);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    end
    $finish;
  end
endmodule